// File: doc/BRIEF.md
# MDIO Management Command Engine

This block lets software reach the management registers of an external Ethernet PHY through a small register window. Software puts a PHY address, a PHY register number and a read or write request together into one 16-bit command word and writes it to the command register. For a write, the 16-bit value to send must already be in the write-data register. The engine then sends one clause-22 management frame on MDC/MDIO. The MDIO pin is split into an output value, an output enable and an input, so that a pad or a bench can form the shared open line.

While the frame is on the wire, the request bit that started it reads back as 1 from the command register, and software polls that bit. The bit clears in the same clock edge that ends the frame. For a read, the read-data register takes the 16 bits sampled from the PHY in that same edge. If no PHY answers, the line floats high through its pull-up, so the read returns all ones. Command writes that arrive while a frame is running are dropped. So are command words that request both operations or neither.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, and whenever no frame is running, MDIO is not driven (mdio_oe = 0). During reset MDC is low, and the command, write-data and read-data registers read 0.
- R2: The register offsets are: 0 = command, 1 = write data, 2 = read data (offset 3 reads 0). In a command word, bits 12:8 hold the PHY address, bits 4:0 hold the register number, bit 13 requests a read and bit 14 requests a write. A write frame drives 32 ones, then start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10 and the 16 data bits, with every field sent MSB first.
- R3: A read frame drives opcode 10 and stops driving MDIO for the two turnaround bits and the 16 data bits. It samples each data bit just before a rising MDC edge and places the 16-bit result in the read-data register.
- R4: The command register reads back {0, write-busy, read-busy, PHY address, 000, register number}. The request bit of the running frame reads 1 from the cycle after the command write until the frame ends, and reads 0 after that.
- R5: A command write that arrives while a frame is running has no effect. It does not change the command readback and does not start another frame.
- R6: A command word that has bits 14 and 13 both set, or both clear, is ignored. No frame starts and the readback does not change.
- R7: A read addressed to a PHY that does not drive the line returns 0xFFFF.
- R8: MDC has a period of CLK_DIV clock cycles and spends CLK_DIV/2 of them high. MDIO and its enable change only in the cycle where MDC falls.
- R9: The write-data register reads back what was last written to it. The engine captures its value when a write frame starts, so writing the register during the frame does not change the frame's data.
- R10: The read-data register updates in the same cycle that the read request bit clears, so the first poll that sees the bit at 0 already returns the new data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| mdc_o | output | 1 | Management clock toward the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; 0 releases the line |
| mdio_i | input | 1 | MDIO line level as seen at the pad |

## Verification
Two events meet in one clock edge: a frame completes, and the request bit clears. For a read, the read-data register loads the sampled result in that same edge. The bench polls the command register in every cycle. In the first cycle that shows the request bit at 0, it reads the read-data register too and expects the newly read PHY value, not the previous one. A second overlap is a command write that lands while a frame is running. The bench issues one mid-frame and checks that the readback does not change and that the PHY model sees no extra frame.

// File: rtl/mdio_ctl_pkg.sv
// Package: shared constants and types for the MDIO management engine.
// Assumes a 16-bit register window with a 2-bit offset and clause-22 frames only.
package mdio_ctl_pkg;

    localparam int ADDR_W     = 2;
    localparam int DATA_W     = 16;
    localparam int FRAME_BITS = 32;   // start through data, after the preamble

    localparam logic [ADDR_W-1:0] OFS_CMD   = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_WDATA = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_RDATA = 2'd2;

    localparam int BIT_RD_REQ = 13;
    localparam int BIT_WR_REQ = 14;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regn;
        mdio_op_e   op;
    } mdio_cmd_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: free-running MDC generator.
// Divides clk by CLK_DIV (even, at least 4) and gives one-cycle strobes in the
// cycle before MDC rises and in the cycle before MDC falls. MDC is low out of reset.
module mdio_mdc_gen #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = $clog2(CLK_DIV);
    localparam int HALF  = CLK_DIV / 2;

    logic [CNT_W-1:0] cnt_q;

    // Phase counter that wraps once per MDC period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == CNT_W'(CLK_DIV - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // MDC is high in the upper half of the period; the strobes lead each edge by one cycle.
    always_comb begin
        mdc       = (cnt_q >= CNT_W'(HALF));
        rise_tick = (cnt_q == CNT_W'(HALF - 1));
        fall_tick = (cnt_q == CNT_W'(CLK_DIV - 1));
    end
endmodule

// File: rtl/mdio_regs.sv
// Module: software register window of the MDIO engine.
// Holds the command fields, the write data and the read result. It decodes a legal
// command write into a start pulse. Writes to the command offset are dropped while
// the engine is busy. Assumes at most one register access per cycle.
module mdio_regs
    import mdio_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_busy,
    input  mdio_op_e          eng_op,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rd_value,
    output logic              start,
    output mdio_cmd_t         start_cmd,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] cmd_view
);
    logic [4:0]        phy_q;
    logic [4:0]        regn_q;
    logic [DATA_W-1:0] rdata_q;
    logic              req_rd;
    logic              req_wr;
    logic              unused_cmd_bits;

    // Decode the incoming command word and decide whether it starts a frame.
    always_comb begin
        req_rd          = bus_wdata[BIT_RD_REQ];
        req_wr          = bus_wdata[BIT_WR_REQ];
        start           = bus_wr && (bus_addr == OFS_CMD) && !eng_busy && (req_rd ^ req_wr);
        start_cmd.phy   = bus_wdata[12:8];
        start_cmd.regn  = bus_wdata[4:0];
        start_cmd.op    = req_rd ? OP_READ : OP_WRITE;
        unused_cmd_bits = ^{bus_wdata[15], bus_wdata[7:5]};
    end

    // Command fields are stored only when a frame actually starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q  <= '0;
            regn_q <= '0;
        end else if (start) begin
            phy_q  <= start_cmd.phy;
            regn_q <= start_cmd.regn;
        end
    end

    // Write-data register, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdata_q <= '0;
        else if (bus_wr && (bus_addr == OFS_WDATA))
            wdata_q <= bus_wdata;
    end

    // Read result loads in the edge that ends a read frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (eng_done && (eng_op == OP_READ))
            rdata_q <= eng_rd_value;
    end

    // Command readback with live request bits.
    always_comb begin
        cmd_view        = '0;
        cmd_view[BIT_WR_REQ] = eng_busy && (eng_op == OP_WRITE);
        cmd_view[BIT_RD_REQ] = eng_busy && (eng_op == OP_READ);
        cmd_view[12:8]  = phy_q;
        cmd_view[4:0]   = regn_q;
    end

    // Read mux for the register window.
    always_comb begin
        case (bus_addr)
            OFS_CMD:   bus_rdata = cmd_view;
            OFS_WDATA: bus_rdata = wdata_q;
            OFS_RDATA: bus_rdata = rdata_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Module: clause-22 frame sequencer.
// On start it captures the command and data. On each MDC fall strobe it drives
// the next bit: PRE_LEN ones, then the 32-bit frame MSB first. For reads it
// releases the line from the turnaround on and shifts in 16 bits, one at each
// MDC rise strobe. done is high in the cycle whose edge ends the frame.
// Assumes mdio_i is already synchronous to clk.
module mdio_frame_engine
    import mdio_ctl_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         start_cmd,
    input  logic [DATA_W-1:0] start_data,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output mdio_op_e          op,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_value
);
    localparam int TOTAL   = PRE_LEN + FRAME_BITS;
    localparam int IDX_W   = $clog2(TOTAL + 1);
    localparam int TA_POS  = PRE_LEN + 14;   // first turnaround bit
    localparam int SAMP_LO = PRE_LEN + 17;   // index held after the first data bit is driven

    logic [IDX_W-1:0]      idx_q;
    logic                  busy_q;
    mdio_op_e              op_q;
    logic [FRAME_BITS-1:0] frame_q;
    logic [DATA_W-1:0]     shift_q;
    logic                  out_q;
    logic                  oe_q;
    logic [4:0]            frame_pos;
    logic                  nxt_bit;
    logic                  nxt_oe;
    logic                  last_bit;
    logic [FRAME_BITS-1:0] frame_build;

    // Assemble the frame word from the captured command.
    always_comb begin
        if (start_cmd.op == OP_WRITE)
            frame_build = {2'b01, start_cmd.op, start_cmd.phy, start_cmd.regn, 2'b10, start_data};
        else
            frame_build = {2'b01, start_cmd.op, start_cmd.phy, start_cmd.regn, 2'b11, 16'hFFFF};
    end

    // Select the next bit to put on the line and whether it is driven.
    always_comb begin
        frame_pos = 5'(TOTAL - 1 - int'(idx_q));
        last_bit  = (idx_q == IDX_W'(TOTAL));
        nxt_bit   = (idx_q < IDX_W'(PRE_LEN)) ? 1'b1 : frame_q[frame_pos];
        nxt_oe    = (op_q == OP_WRITE) || (idx_q < IDX_W'(TA_POS));
    end

    // Frame state: start, bit stepping on MDC falls, and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            op_q    <= OP_WRITE;
            frame_q <= '0;
            out_q   <= 1'b1;
            oe_q    <= 1'b0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                idx_q   <= '0;
                op_q    <= start_cmd.op;
                frame_q <= frame_build;
            end
        end else if (fall_tick) begin
            if (last_bit) begin
                busy_q <= 1'b0;
                out_q  <= 1'b1;
                oe_q   <= 1'b0;
            end else begin
                out_q <= nxt_bit;
                oe_q  <= nxt_oe;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Read data capture just before each rising MDC edge of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shift_q <= '0;
        else if (busy_q && rise_tick && (op_q == OP_READ) && (idx_q >= IDX_W'(SAMP_LO)))
            shift_q <= {shift_q[DATA_W-2:0], mdio_i};
    end

    // Outputs toward the register window and the pad.
    always_comb begin
        busy     = busy_q;
        op       = op_q;
        mdio_o   = out_q;
        mdio_oe  = oe_q;
        done     = busy_q && fall_tick && last_bit;
        rd_value = shift_q;
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// Module: top of the MDIO management command engine.
// Connects the register window, the MDC generator and the frame sequencer.
// Assumes an external pull-up on MDIO and an mdio_i already synchronous to clk.
module mdio_mgmt_ctrl
    import mdio_ctl_pkg::*;
#(
    parameter int CLK_DIV = 8,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              rise_tick;
    logic              fall_tick;
    logic              eng_busy;
    mdio_op_e          eng_op;
    logic              eng_done;
    logic [DATA_W-1:0] eng_rd_value;
    logic              start;
    mdio_cmd_t         start_cmd;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] cmd_view;

    mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc       (mdc_o),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .eng_busy     (eng_busy),
        .eng_op       (eng_op),
        .eng_done     (eng_done),
        .eng_rd_value (eng_rd_value),
        .start        (start),
        .start_cmd    (start_cmd),
        .wdata_q      (wdata_q),
        .cmd_view     (cmd_view)
    );

    mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_cmd  (start_cmd),
        .start_data (wdata_q),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .mdio_i     (mdio_i),
        .busy       (eng_busy),
        .op         (eng_op),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .done       (eng_done),
        .rd_value   (eng_rd_value)
    );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
// Module: assertion checker for the MDIO management engine, bound to the top.
module mdio_mgmt_ctrl_chk #(
    parameter int CLK_DIV = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [1:0]  cmd_req,
    input logic        mdc_o,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        eng_busy,
    input logic [15:0] cmd_view
);
    logic        mdc_prev;
    logic        seen_rise;
    logic [15:0] gap;

    // Track cycles since the last MDC rise to check the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_prev  <= 1'b0;
            seen_rise <= 1'b0;
            gap       <= '0;
        end else begin
            mdc_prev <= mdc_o;
            if (mdc_o && !mdc_prev) begin
                seen_rise <= 1'b1;
                gap       <= '0;
            end else begin
                gap <= gap + 1'b1;
            end
        end
    end

    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mdio_oe);

    p_one_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_view[14:13]));

    p_busy_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && bus_wr && bus_addr == 2'd0) |=> $stable(cmd_view[12:0]));

    p_bad_request_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_busy && bus_wr && bus_addr == 2'd0 && (cmd_req == 2'b11 || cmd_req == 2'b00))
        |=> !eng_busy);

    p_mdio_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdio_o) || !$stable(mdio_oe)) |-> $fell(mdc_o));

    p_mdc_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && !mdc_prev && seen_rise) |-> (gap == 16'(CLK_DIV - 1)));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .cmd_req  (bus_wdata[14:13]),
    .mdc_o    (mdc_o),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .eng_busy (eng_busy),
    .cmd_view (cmd_view)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/100ps
module mdio_mgmt_ctrl_bench;
    localparam int CLK_DIV = 8;
    localparam logic [4:0] PHY_ADR = 5'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;
    logic        phy_en = 1'b0;
    logic        phy_bit = 1'b1;

    int checks = 0;
    int fails  = 0;

    // PHY model state
    logic [15:0] phy_mem [32];
    int          frames_seen = 0;
    int          last_pre = 0;
    logic        last_st = 1'b0;
    logic [1:0]  last_op = 2'b00;
    logic [4:0]  last_pa = 5'd0;
    logic [4:0]  last_ra = 5'd0;
    logic [1:0]  last_ta = 2'b00;
    logic [15:0] last_data = 16'h0;
    logic        clash = 1'b0;
    int          viol = 0;
    logic        prev_o = 1'b1;
    logic        prev_oe = 1'b0;
    logic        prev_mdc = 1'b0;

    always #2.5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

    mdio_mgmt_ctrl #(.CLK_DIV(CLK_DIV)) u_mdio_mgmt_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc_o     (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Poll the command register every cycle; in the first idle cycle read the result too.
    task automatic wait_idle(output logic [15:0] rd_at_clear);
        rd_at_clear = 16'h0;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            bus_addr = 2'd0;
            #0.5;
            if (bus_rdata[14:13] == 2'b00) begin
                bus_addr = 2'd2;
                #0.5;
                rd_at_clear = bus_rdata;
                return;
            end
        end
        chk("R4 request bit never cleared", 32'd1, 32'd0);
    endtask

    // PHY model: decodes frames on MDC rises and answers reads on MDC falls.
    initial begin
        int ones;
        logic [11:0] hdr;
        logic [1:0]  ta;
        logic [15:0] dat;
        for (int i = 0; i < 32; i++) phy_mem[i] = 16'h0;
        phy_mem[7] = 16'h1234;
        forever begin
            ones = 0;
            forever begin
                @(posedge mdc);
                if (mdio_oe && mdio_i) ones++;
                else if (mdio_oe && !mdio_i && ones >= 32) break;
                else ones = 0;
            end
            last_pre = ones;
            @(posedge mdc);
            last_st = mdio_i;
            hdr = 12'h0;
            for (int i = 0; i < 12; i++) begin
                @(posedge mdc);
                hdr = {hdr[10:0], mdio_i};
            end
            last_op = hdr[11:10];
            last_pa = hdr[9:5];
            last_ra = hdr[4:0];
            if (hdr[11:10] == 2'b10) begin
                @(negedge mdc);
                @(negedge mdc);
                if (hdr[9:5] == PHY_ADR) begin phy_en = 1'b1; phy_bit = 1'b0; end
                for (int i = 15; i >= 0; i--) begin
                    @(negedge mdc);
                    phy_bit = phy_mem[hdr[4:0]][i];
                end
                @(negedge mdc);
                phy_en = 1'b0;
            end else begin
                ta = 2'b00;
                dat = 16'h0;
                for (int i = 0; i < 2; i++) begin @(posedge mdc); ta = {ta[0], mdio_i}; end
                for (int i = 0; i < 16; i++) begin @(posedge mdc); dat = {dat[14:0], mdio_i}; end
                last_ta = ta;
                last_data = dat;
                if (hdr[9:5] == PHY_ADR) phy_mem[hdr[4:0]] = dat;
            end
            frames_seen++;
        end
    end

    always @(posedge mdc) if (phy_en && mdio_oe) clash = 1'b1;

    // Line changes must coincide with MDC falling.
    always @(negedge clk) begin
        if (rst_n && ((mdio_o !== prev_o) || (mdio_oe !== prev_oe)) &&
            !(prev_mdc === 1'b1 && mdc === 1'b0))
            viol++;
        prev_o = mdio_o; prev_oe = mdio_oe; prev_mdc = mdc;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic t_reset();
        logic [15:0] d;
        repeat (3) @(posedge clk);
        bus_read(2'd0, d); chk("R1 cmd after reset", 32'(d), 32'h0);
        bus_read(2'd1, d); chk("R1 wdata after reset", 32'(d), 32'h0);
        bus_read(2'd2, d); chk("R1 rdata after reset", 32'(d), 32'h0);
        chk("R1 mdc low in reset", 32'(mdc), 32'h0);
        chk("R1 mdio released in reset", 32'(mdio_oe), 32'h0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_write();
        logic [15:0] d;
        int f0;
        f0 = frames_seen;
        bus_write(2'd1, 16'hA5C3);
        bus_write(2'd0, 16'h4311);
        bus_read(2'd0, d); chk("R4 write request bit set", 32'(d), 32'h4311);
        wait_idle(d);
        bus_read(2'd0, d); chk("R4 request bit cleared", 32'(d), 32'h0311);
        chk("R2 one frame", 32'(frames_seen - f0), 32'd1);
        chk("R2 preamble ones", 32'(last_pre), 32'd32);
        chk("R2 start bits", 32'(last_st), 32'd1);
        chk("R2 write opcode", 32'(last_op), 32'h1);
        chk("R2 phy address", 32'(last_pa), 32'h3);
        chk("R2 register number", 32'(last_ra), 32'h11);
        chk("R2 turnaround", 32'(last_ta), 32'h2);
        chk("R2 data", 32'(last_data), 32'hA5C3);
        chk("R1 idle release", 32'(mdio_oe), 32'h0);
    endtask

    task automatic t_read(input logic [15:0] cmd, input logic [15:0] exp, input string tag);
        logic [15:0] d;
        bus_write(2'd0, cmd);
        bus_read(2'd0, d); chk({tag, " R4 read request bit set"}, 32'(d[14:13]), 32'h1);
        wait_idle(d);
        chk({tag, " R10 data at first idle poll"}, 32'(d), 32'(exp));
        chk({tag, " R3 read opcode"}, 32'(last_op), 32'h2);
        bus_read(2'd2, d); chk({tag, " R3 read-data register"}, 32'(d), 32'(exp));
    endtask

    task automatic t_busy_ignore();
        logic [15:0] d;
        int f0;
        f0 = frames_seen;
        bus_write(2'd0, 16'h2307);
        repeat (20) @(negedge clk);
        bus_write(2'd0, 16'h4A0B);
        bus_read(2'd0, d); chk("R5 readback unchanged", 32'(d), 32'h2307);
        wait_idle(d);
        chk("R5 running read completes", 32'(d), 32'h1234);
        repeat (1200) @(negedge clk);
        chk("R5 no extra frame", 32'(frames_seen - f0), 32'd1);
        bus_read(2'd0, d); chk("R5 fields kept", 32'(d), 32'h0307);
    endtask

    task automatic t_bad_request();
        logic [15:0] d;
        int f0;
        f0 = frames_seen;
        bus_write(2'd0, 16'h6A0B);
        bus_read(2'd0, d); chk("R6 both bits ignored", 32'(d), 32'h0307);
        bus_write(2'd0, 16'h0A0B);
        bus_read(2'd0, d); chk("R6 no bits ignored", 32'(d), 32'h0307);
        repeat (1200) @(negedge clk);
        chk("R6 no frame", 32'(frames_seen - f0), 32'd0);
        chk("R6 line released", 32'(mdio_oe), 32'h0);
    endtask

    task automatic t_wdata_capture();
        logic [15:0] d;
        bus_write(2'd1, 16'h0F0F);
        bus_write(2'd0, 16'h4305);
        repeat (100) @(negedge clk);
        bus_write(2'd1, 16'hFFFF);
        wait_idle(d);
        chk("R9 frame data captured at start", 32'(last_data), 32'h0F0F);
        bus_read(2'd1, d); chk("R9 wdata readback", 32'(d), 32'hFFFF);
    endtask

    task automatic t_mdc_timing();
        int r0, r1, hi, n;
        logic p;
        r0 = -1; r1 = -1; hi = 0; n = 0;
        @(negedge clk); p = mdc;
        while (r1 < 0 && n < 100) begin
            @(negedge clk); n++;
            if (mdc && !p) begin
                if (r0 < 0) r0 = n; else r1 = n;
            end
            if (r0 >= 0 && r1 < 0 && mdc) hi++;
            p = mdc;
        end
        chk("R8 mdc period", 32'(r1 - r0), 32'(CLK_DIV));
        chk("R8 mdc high time", 32'(hi), 32'(CLK_DIV / 2));
        chk("R8 line changes only at mdc fall", 32'(viol), 32'd0);
        chk("R3 no drive clash in read", 32'(clash), 32'd0);
    endtask

    initial begin
        t_reset();
        t_write();
        t_read(16'h2311, 16'hA5C3, "readback");
        t_read(16'h2307, 16'h1234, "preset");
        t_busy_ignore();
        t_bad_request();
        t_read(16'h2902, 16'hFFFF, "R7 absent phy");
        t_wdata_capture();
        t_mdc_timing();
        summary();
        $finish;
    end
endmodule